// File: doc/BRIEF.md
# Three-Carrier Phase-Shifted PWM Generator

This block drives the switch legs of a three-phase series converter. Each phase is a stack of H-bridge modules (three by default), so the block serves nine modules. It runs one up/down triangular carrier per module position in a phase. The carriers start spread evenly over one carrier period, a third of a period apart by default. Each phase supplies a single signed reference. That reference is compared with every carrier, so the modules of one phase switch at staggered instants, and the summed phase voltage steps at several times the rate of a single module.

Each module gets a 2-bit leg state and gives unipolar three-level output. The positive leg is on while the reference is above its carrier, and the negative leg is on while the negated reference is above it. A module takes a new reference only while its own carrier sits at its peak, so a duty value never changes part way through a half period. A one-cycle change strobe marks every cycle in which a module's leg state differs from the state it held one cycle earlier. With enable low, every leg is off and the carriers are parked at their starting phases. The next enable therefore always begins from a known phase relation.

Top module: `pscpwm_gen`

## Requirements
- R1: While reset is asserted, every leg state reads 00 and every change strobe reads 0.
- R2: While enabled, carrier k steps by exactly one per clock between 0 and `peak`. It rises to `peak`, then falls to 0, so one full period takes 2*`peak` clocks.
- R3: On each clock with enable low, carrier k is loaded with unfolded phase floor(2*`peak`*k/NMOD). A phase ph below `peak` means value ph, rising. Any other phase means value 2*`peak`-ph, falling.
- R4: Module m of phase p sits at flat index i = p*NMOD+m and uses `leg_state[2i+1:2i]`. Bit 2i+1 (positive leg) is set when the held reference is greater than carrier m. Bit 2i (negative leg) is set when the negated held reference is greater than carrier m. Both compares are signed, and the leg state is registered one clock after the inputs it uses.
- R5: While enabled, a module loads its phase reference, read as a two's-complement value from `phase_ref[p*RW +: RW]`, only on a clock where its carrier is at or above `peak`. A reference change at any other time has no effect until that point.
- R6: `leg_chg[i]` is 1 in exactly those cycles where `leg_state[2i+1:2i]` differs from its value in the previous cycle.
- R7: One clock after enable is sampled low, every leg state is 00. While enable is low, every module's held reference follows its phase input.
- R8: The two legs of one module are never both set.
- R9: A zero reference keeps both legs of a module off. A reference above `peak` keeps the positive leg on. A reference below -`peak` keeps the negative leg on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low parks carriers and turns legs off |
| peak | input | CW | Carrier peak value |
| phase_ref | input | NPH*RW | Signed reference per phase, phase p at bits p*RW +: RW |
| leg_state | output | NPH*NMOD*2 | Leg pair per module, {positive, negative} |
| leg_chg | output | NPH*NMOD | One-cycle strobe per module on a leg state change |

## Verification
Constant references over several periods show the triangle shape and the starting phase offsets, because the three modules of each phase switch at distinct, predictable cycles. References that change on every cycle separate correct peak-only loading from loading that happens continuously. Zero, most-positive and most-negative references exercise the signed compare and negation edges. Randomised peaks, including 0 and 1, with random enable gaps and reference updates cover restarts from the parked phase and strobe timing against a cycle model.

// File: rtl/pscpwm_pkg.sv
package pscpwm_pkg;

    // Leg pair encoding: bit 1 = positive leg, bit 0 = negative leg
    typedef enum logic [1:0] {
        LEG_OFF = 2'b00,
        LEG_NEG = 2'b01,
        LEG_POS = 2'b10
    } leg_e;

endpackage

// File: rtl/pscpwm_carrier.sv
module pscpwm_carrier #(
    parameter int CW   = 16,
    parameter int NMOD = 3,
    parameter int IDX  = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] peak,
    output logic [CW-1:0] car,
    output logic          at_peak
);
    localparam int PW = CW + 2 + $clog2(NMOD + 1);

    typedef struct packed {
        logic [CW-1:0] val;
        logic          dn;
    } car_s;

    car_s          d, q;
    logic [PW-1:0] ph;

    always_comb begin
        d       = q;
        ph      = (PW'(peak) * PW'(2 * IDX)) / PW'(NMOD);
        at_peak = en && (q.val >= peak);
        if (!en) begin
            if (ph < PW'(peak)) begin
                d.val = CW'(ph);
                d.dn  = 1'b0;
            end else begin
                d.val = CW'((PW'(peak) << 1) - ph);
                d.dn  = 1'b1;
            end
        end else if (!q.dn) begin
            if ((CW + 1)'(q.val) + (CW + 1)'(1) >= (CW + 1)'(peak)) begin
                d.val = peak;
                d.dn  = 1'b1;
            end else begin
                d.val = q.val + CW'(1);
            end
        end else begin
            if (q.val <= CW'(1)) begin
                d.val = '0;
                d.dn  = 1'b0;
            end else begin
                d.val = q.val - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign car = q.val;

endmodule

// File: rtl/pscpwm_cell.sv
module pscpwm_cell
    import pscpwm_pkg::*;
#(
    parameter int CW = 16,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          at_peak,
    input  logic [CW-1:0] car,
    input  logic [RW-1:0] ref_in,
    output logic [1:0]    leg,
    output logic          chg
);
    localparam int XW = ((RW > CW) ? RW : CW) + 2;

    typedef struct packed {
        logic [RW-1:0] ref_v;
        logic [1:0]    leg;
        logic          chg;
    } cell_s;

    cell_s                d, q;
    logic signed [XW-1:0] r_x, n_x, c_x;
    logic                 pos_on, neg_on;

    always_comb begin
        d      = q;
        r_x    = XW'($signed(q.ref_v));
        n_x    = -r_x;
        c_x    = $signed({{(XW - CW){1'b0}}, car});
        pos_on = r_x > c_x;
        neg_on = n_x > c_x;
        d.leg  = en ? {pos_on, neg_on} : LEG_OFF;
        d.chg  = d.leg != q.leg;
        if (!en || at_peak) d.ref_v = ref_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign leg = q.leg;
    assign chg = q.chg;

endmodule

// File: rtl/pscpwm_gen.sv
module pscpwm_gen #(
    parameter int CW   = 16,
    parameter int RW   = 16,
    parameter int NPH  = 3,
    parameter int NMOD = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [CW-1:0]           peak,
    input  logic [NPH*RW-1:0]       phase_ref,
    output logic [NPH*NMOD*2-1:0]   leg_state,
    output logic [NPH*NMOD-1:0]     leg_chg
);
    logic [NMOD*CW-1:0] car_val;
    logic [NMOD-1:0]    car_top;

    for (genvar k = 0; k < NMOD; k++) begin : g_car
        pscpwm_carrier #(.CW(CW), .NMOD(NMOD), .IDX(k)) u_car (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en),
            .peak    (peak),
            .car     (car_val[k*CW +: CW]),
            .at_peak (car_top[k])
        );
    end

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        for (genvar m = 0; m < NMOD; m++) begin : g_mod
            localparam int I = p * NMOD + m;
            pscpwm_cell #(.CW(CW), .RW(RW)) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (en),
                .at_peak (car_top[m]),
                .car     (car_val[m*CW +: CW]),
                .ref_in  (phase_ref[p*RW +: RW]),
                .leg     (leg_state[2*I +: 2]),
                .chg     (leg_chg[I])
            );
        end
    end

endmodule

// File: rtl/pscpwm_chk.sv
module pscpwm_chk #(
    parameter int CW   = 16,
    parameter int NPH  = 3,
    parameter int NMOD = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  en,
    input logic [CW-1:0]         peak,
    input logic [NMOD*CW-1:0]    car_val,
    input logic [NPH*NMOD*2-1:0] leg_state,
    input logic [NPH*NMOD-1:0]   leg_chg
);
    for (genvar k = 0; k < NMOD; k++) begin : g_car
        // R2: one step per clock inside the range
        assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (en && car_val[k*CW +: CW] > 0 && car_val[k*CW +: CW] < peak) |=>
            ((car_val[k*CW +: CW] == $past(car_val[k*CW +: CW]) + 1) ||
             (car_val[k*CW +: CW] == $past(car_val[k*CW +: CW]) - 1)));
        // R2: turns downward after the peak
        assert_peak_turn_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (en && peak != 0 && $stable(peak) && car_val[k*CW +: CW] == peak) |=>
            (car_val[k*CW +: CW] == $past(peak) - 1));
    end

    for (genvar i = 0; i < NPH * NMOD; i++) begin : g_mod
        assert_no_shoot_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(leg_state[2*i] && leg_state[2*i+1]));
        assert_chg_real_R6: assert property (@(posedge clk) disable iff (!rst_n)
            leg_chg[i] |-> (leg_state[2*i +: 2] != $past(leg_state[2*i +: 2])));
        assert_chg_seen_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (leg_state[2*i +: 2] != $past(leg_state[2*i +: 2])) |-> leg_chg[i]);
    end

    assert_off_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (leg_state == '0));

endmodule

bind pscpwm_gen pscpwm_chk #(.CW(CW), .NPH(NPH), .NMOD(NMOD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .peak      (peak),
    .car_val   (car_val),
    .leg_state (leg_state),
    .leg_chg   (leg_chg)
);

// File: tb/tb_pscpwm_gen.sv
module tb_pscpwm_gen;
    localparam int CW = 16, RW = 16, NPH = 3, NMOD = 3, NM = NPH * NMOD;

    logic                 clk = 0;
    logic                 rst_n = 0;
    logic                 en = 0;
    logic [CW-1:0]        peak = 16'd6;
    logic [NPH*RW-1:0]    phase_ref;
    logic [NM*2-1:0]      leg_state;
    logic [NM-1:0]        leg_chg;

    int    ref_i [NPH];
    int    n_run = 0, n_fail = 0;
    bit    chk_on = 0;
    string cur_tag = "R1";

    // model state
    int       mv  [NMOD];
    bit       mdn [NMOD];
    int       mref[NPH][NMOD];
    bit [1:0] mleg[NPH][NMOD];
    bit       mchg[NPH][NMOD];

    always #2 clk = ~clk;

    always_comb for (int p = 0; p < NPH; p++) phase_ref[p*RW +: RW] = RW'(ref_i[p]);

    pscpwm_gen #(.CW(CW), .RW(RW), .NPH(NPH), .NMOD(NMOD)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .peak(peak),
        .phase_ref(phase_ref), .leg_state(leg_state), .leg_chg(leg_chg));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // cycle model built from the requirements
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NMOD; k++) begin mv[k] = 0; mdn[k] = 0; end
            for (int p = 0; p < NPH; p++)
                for (int m = 0; m < NMOD; m++) begin
                    mref[p][m] = 0; mleg[p][m] = 0; mchg[p][m] = 0;
                end
        end else begin
            int pk;
            pk = int'(peak);
            for (int p = 0; p < NPH; p++)
                for (int m = 0; m < NMOD; m++) begin
                    bit [1:0] nl;
                    nl[1] = en && (mref[p][m] > mv[m]);
                    nl[0] = en && (-mref[p][m] > mv[m]);
                    mchg[p][m] = nl != mleg[p][m];
                    mleg[p][m] = nl;
                    if (!en || mv[m] >= pk) mref[p][m] = ref_i[p];
                end
            for (int k = 0; k < NMOD; k++) begin
                if (!en) begin
                    int ph;
                    ph = (2 * pk * k) / NMOD;
                    if (ph < pk) begin mv[k] = ph; mdn[k] = 0; end
                    else begin mv[k] = 2 * pk - ph; mdn[k] = 1; end
                end else if (!mdn[k]) begin
                    if (mv[k] + 1 >= pk) begin mv[k] = pk; mdn[k] = 1; end
                    else mv[k] = mv[k] + 1;
                end else begin
                    if (mv[k] <= 1) begin mv[k] = 0; mdn[k] = 0; end
                    else mv[k] = mv[k] - 1;
                end
            end
        end
    end

    always @(negedge clk) if (chk_on) begin
        for (int p = 0; p < NPH; p++)
            for (int m = 0; m < NMOD; m++) begin
                int i;
                i = p * NMOD + m;
                check(leg_state[2*i +: 2] == mleg[p][m], cur_tag,
                      int'(leg_state[2*i +: 2]), int'(mleg[p][m]));
                check(leg_chg[i] == mchg[p][m], "R6 strobe", int'(leg_chg[i]), int'(mchg[p][m]));
                check(leg_state[2*i +: 2] != 2'b11, "R8 both legs", int'(leg_state[2*i +: 2]), 0);
            end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h2468ACE1));
        for (int p = 0; p < NPH; p++) ref_i[p] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(leg_state == '0, "R1 legs", int'(leg_state), 0);
        check(leg_chg == '0, "R1 strobes", int'(leg_chg), 0);
        chk_on = 1;

        // R7: enabled low, references present
        @(negedge clk); rst_n = 1; cur_tag = "R7";
        ref_i[0] = 3; ref_i[1] = -2; ref_i[2] = 5;
        repeat (4) @(negedge clk);
        check(leg_state == '0, "R7 idle legs", int'(leg_state), 0);

        // R3: start phases, then R2 triangle shape
        en = 1; cur_tag = "R3";
        repeat (12) @(negedge clk);
        cur_tag = "R2";
        repeat (40) @(negedge clk);

        // R5: references change every cycle
        cur_tag = "R5";
        repeat (60) begin
            for (int p = 0; p < NPH; p++) ref_i[p] = int'($urandom_range(16)) - 8;
            @(negedge clk);
        end

        // R9: zero and extreme references
        cur_tag = "R9";
        ref_i[0] = 0; ref_i[1] = 32767; ref_i[2] = -32768;
        repeat (20) @(negedge clk);
        check(leg_state[5:0] == 6'b000000, "R9 zero ref", int'(leg_state[5:0]), 0);
        check(leg_state[11:6] == 6'b101010, "R9 max ref", int'(leg_state[11:6]), 6'b101010);
        check(leg_state[17:12] == 6'b010101, "R9 min ref", int'(leg_state[17:12]), 6'b010101);

        // R7: drop enable while running
        en = 0; cur_tag = "R7";
        @(negedge clk);
        check(leg_state == '0, "R7 legs off", int'(leg_state), 0);
        repeat (2) @(negedge clk);

        // R4: random peaks, restarts and references
        cur_tag = "R4";
        for (int r = 0; r < 40; r++) begin
            en = 0;
            peak = CW'((r < 2) ? r : $urandom_range(40));
            @(negedge clk); @(negedge clk);
            en = 1;
            repeat ($urandom_range(120, 20)) begin
                if ($urandom_range(3) == 0)
                    for (int p = 0; p < NPH; p++)
                        ref_i[p] = int'($urandom_range(2 * int'(peak) + 8)) - int'(peak) - 4;
                @(negedge clk);
            end
        end

        chk_on = 0;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule